// File: doc/BRIEF.md
# Packed 4:2:2 YCbCr to RGB Pixel Converter

This block turns a stream of packed 4:2:2 words into full-range RGB pixels, one pixel per clock. Each input word holds two pixels that share a single pair of chroma samples. The byte order inside the word is selectable. The colour matrix is programmable: three output rows each hold three multipliers (for Y, Cb and Cr) and one additive constant. The reset contents give the standard-definition video-range conversion: Y 16..235 and chroma 16..240 in, 0..255 out.

Software writes the coefficient words and the order code through a simple write port. The pixel source offers words with a valid/ready handshake. Converted pixels leave on a valid-qualified output that has no back-pressure. Each channel is a fixed-point sum of three products and a scaled constant, rounded and saturated to 8 bits, computed in a three-stage pipeline.

Top module: `ycc_rgb_cvt`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and the order code is 0. The matrix holds, as signed values, G row (Y 1191, Cb -401, Cr -833, constant 2167), R row (1191, 0, 1634, -3567) and B row (1191, 2066, 0, -4431).
- R2: Each channel equals floor((Y*kY + Cb*kCb + Cr*kCr + 64*kC + 512) / 1024), then saturated. Multipliers carry 10 fraction bits and constants carry 4, and ties round upward.
- R3: Register index 4*row + term selects a coefficient. Term 0 is the Y multiplier, 1 the Cb multiplier, 2 the Cr multiplier and 3 the constant. Row 0 produces G, row 1 R and row 2 B. out_rgb packs R in [23:16], G in [15:8] and B in [7:0].
- R4: A multiplier write keeps cfg_wdata[12:0] as 13-bit two's complement. A constant write keeps cfg_wdata[13:0] as 14-bit two's complement. Higher data bits are ignored.
- R5: A channel whose rounded result is below 0 outputs 0, and one above 255 outputs 255.
- R6: Register index 12 takes the order code from cfg_wdata[1:0]. The first stream byte is in_data[7:0], then [15:8], [23:16] and [31:24]. The codes are: 0 = Y0 Cb Y1 Cr, 1 = Y0 Cr Y1 Cb, 2 = Cb Y0 Cr Y1, 3 = Cr Y0 Cb Y1.
- R7: Both pixels of a word use that word's Cb and Cr. The first pixel out uses Y0 and the second uses Y1.
- R8: For a word accepted on clock edge k, its first pixel is on the output after edge k+3 and its second after edge k+4. out_valid is high in no other cycle.
- R9: in_ready is low in the cycle after an accepted word and high otherwise, so back-to-back words give one pixel per clock.
- R10: Writes to register indices 13, 14 and 15 change neither coefficients nor the order code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 16 | Register write data |
| in_valid | input | 1 | Packed word offered |
| in_ready | output | 1 | Word can be taken this cycle |
| in_data | input | 32 | Packed 4:2:2 word, two pixels |
| out_valid | output | 1 | out_rgb holds a pixel |
| out_rgb | output | 24 | Pixel, R/G/B from high byte to low |

## Verification
Each accepted word yields two results. The first is due three edges after the accepting edge and the second four edges after it. The bench records the edge count at acceptance and queues each expected pixel with the cycle in which it must show. The output is sampled on the falling edge, so both the pixel value and its arrival cycle are compared. in_ready is checked on the falling edge that follows every acceptance. Coefficient writes are made only after the pipeline has drained, so each expected pixel is computed from the matrix that applies to it.

// File: rtl/ycc_rgb_pkg.sv
package ycc_rgb_pkg;

   typedef enum logic [1:0] {
      ORD_Y_CB_Y_CR = 2'd0,
      ORD_Y_CR_Y_CB = 2'd1,
      ORD_CB_Y_CR_Y = 2'd2,
      ORD_CR_Y_CB_Y = 2'd3
   } ycc_order_e;

   localparam int N_ROWS     = 3;
   localparam int N_TERMS    = 4;
   localparam int N_COEF     = N_ROWS * N_TERMS;
   localparam int ADDR_ORDER = N_COEF;

   localparam int ROW_G = 0;
   localparam int ROW_R = 1;
   localparam int ROW_B = 2;

   // Signed reset matrix; multipliers x1024, constants x16
   localparam int BT601_SET [N_COEF] = '{
      1191, -401, -833,  2167,
      1191,    0, 1634, -3567,
      1191, 2066,    0, -4431
   };

endpackage

// File: rtl/ycc_coef_bank.sv
module ycc_coef_bank
   import ycc_rgb_pkg::*;
#(
   parameter int MUL_W  = 13,
   parameter int OFS_W  = 14,
   parameter int CFG_AW = 4,
   parameter int CFG_DW = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [CFG_AW-1:0]             cfg_addr,
   input  logic [CFG_DW-1:0]             cfg_wdata,
   output logic [N_ROWS*3*MUL_W-1:0]     mul_flat,
   output logic [N_ROWS*OFS_W-1:0]       ofs_flat,
   output ycc_order_e                    order_o
);

   localparam int USED_W = (MUL_W > OFS_W) ? MUL_W : OFS_W;

   if (MUL_W < 13 || MUL_W > CFG_DW) begin : g_bad_mul
      $error("ycc_coef_bank: MUL_W out of range");
   end
   if (OFS_W < 14 || OFS_W > CFG_DW) begin : g_bad_ofs
      $error("ycc_coef_bank: OFS_W out of range");
   end
   if ((1 << CFG_AW) <= ADDR_ORDER) begin : g_bad_aw
      $error("ycc_coef_bank: CFG_AW too small for register map");
   end

   if (USED_W < CFG_DW) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^cfg_wdata[CFG_DW-1:USED_W];
   end

   for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      for (genvar t = 0; t < N_TERMS; t++) begin : g_term
         localparam int IDX = r * N_TERMS + t;
         if (t < 3) begin : g_mul
            logic [MUL_W-1:0] mul_q;
            always_ff @(posedge clk) begin
               if (!rst_n)
                  mul_q <= MUL_W'(BT601_SET[IDX]);
               else if (cfg_we && cfg_addr == CFG_AW'(IDX))
                  mul_q <= cfg_wdata[MUL_W-1:0];
            end
            assign mul_flat[(r*3+t)*MUL_W +: MUL_W] = mul_q;
         end else begin : g_ofs
            logic [OFS_W-1:0] ofs_q;
            always_ff @(posedge clk) begin
               if (!rst_n)
                  ofs_q <= OFS_W'(BT601_SET[IDX]);
               else if (cfg_we && cfg_addr == CFG_AW'(IDX))
                  ofs_q <= cfg_wdata[OFS_W-1:0];
            end
            assign ofs_flat[r*OFS_W +: OFS_W] = ofs_q;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         order_o <= ORD_Y_CB_Y_CR;
      else if (cfg_we && cfg_addr == CFG_AW'(ADDR_ORDER))
         order_o <= ycc_order_e'(cfg_wdata[1:0]);
   end

   AST_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr > CFG_AW'(ADDR_ORDER)) |=>
      ($stable(mul_flat) && $stable(ofs_flat) && $stable(order_o)));   // R10

   AST_ORDER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == CFG_AW'(ADDR_ORDER)) |=>
      (order_o == ycc_order_e'($past(cfg_wdata[1:0]))));               // R6

endmodule

// File: rtl/ycc_pair_unpack.sv
module ycc_pair_unpack
   import ycc_rgb_pkg::*;
#(
   parameter int PIX_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [4*PIX_W-1:0] in_data,
   input  ycc_order_e         order_i,
   output logic               pix_valid,
   output logic [PIX_W-1:0]   pix_y,
   output logic [PIX_W-1:0]   pix_cb,
   output logic [PIX_W-1:0]   pix_cr
);

   if (PIX_W < 1) begin : g_bad_w
      $error("ycc_pair_unpack: PIX_W must be positive");
   end

   logic [PIX_W-1:0] b0, b1, b2, b3;
   logic [PIX_W-1:0] y0_d, y1_d, cb_d, cr_d;
   logic [PIX_W-1:0] y0_q, y1_q, cb_q, cr_q;
   logic [1:0]       pend_q;
   logic             accept;
   logic             pix_first;

   assign b0 = in_data[0*PIX_W +: PIX_W];
   assign b1 = in_data[1*PIX_W +: PIX_W];
   assign b2 = in_data[2*PIX_W +: PIX_W];
   assign b3 = in_data[3*PIX_W +: PIX_W];

   always_comb begin
      unique case (order_i)
         ORD_Y_CB_Y_CR: begin y0_d = b0; cb_d = b1; y1_d = b2; cr_d = b3; end
         ORD_Y_CR_Y_CB: begin y0_d = b0; cr_d = b1; y1_d = b2; cb_d = b3; end
         ORD_CB_Y_CR_Y: begin cb_d = b0; y0_d = b1; cr_d = b2; y1_d = b3; end
         default:       begin cr_d = b0; y0_d = b1; cb_d = b2; y1_d = b3; end
      endcase
   end

   assign in_ready  = (pend_q != 2'd2);
   assign accept    = in_valid && in_ready;
   assign pix_valid = (pend_q != 2'd0);
   assign pix_first = (pend_q == 2'd2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 2'd0;
         y0_q   <= '0;
         y1_q   <= '0;
         cb_q   <= '0;
         cr_q   <= '0;
      end else if (accept) begin
         pend_q <= 2'd2;
         y0_q   <= y0_d;
         y1_q   <= y1_d;
         cb_q   <= cb_d;
         cr_q   <= cr_d;
      end else if (pend_q != 2'd0) begin
         pend_q <= pend_q - 2'd1;
      end
   end

   assign pix_y  = pix_first ? y0_q : y1_q;
   assign pix_cb = cb_q;
   assign pix_cr = cr_q;

   AST_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);                           // R9

   AST_CHROMA_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_first) |-> ($stable(pix_cb) && $stable(pix_cr)));  // R7

endmodule

// File: rtl/ycc_mac_row.sv
module ycc_mac_row #(
   parameter int PIX_W         = 8,
   parameter int MUL_W         = 13,
   parameter int OFS_W         = 14,
   parameter int FRAC          = 10,
   parameter int OFS_FRAC      = 4,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [PIX_W-1:0] y_i,
   input  logic [PIX_W-1:0] cb_i,
   input  logic [PIX_W-1:0] cr_i,
   input  logic [MUL_W-1:0] k_y,
   input  logic [MUL_W-1:0] k_cb,
   input  logic [MUL_W-1:0] k_cr,
   input  logic [OFS_W-1:0] k_ofs,
   output logic             out_valid,
   output logic [PIX_W-1:0] out_ch
);

   localparam int SH     = FRAC - OFS_FRAC;
   localparam int PROD_W = PIX_W + 1 + MUL_W;
   localparam int CST_W  = OFS_W + SH;
   localparam int ACC_W  = ((PROD_W > CST_W) ? PROD_W : CST_W) + 2;
   localparam logic signed [ACC_W-1:0] MAXV   = ACC_W'((1 << PIX_W) - 1);
   localparam logic signed [ACC_W-1:0] HI_LIM = ACC_W'((1 << PIX_W) << FRAC);

   if (FRAC < OFS_FRAC || FRAC < 1) begin : g_bad_frac
      $error("ycc_mac_row: FRAC must be at least OFS_FRAC and nonzero");
   end

   // stage 1: products and aligned constant
   logic signed [PROD_W-1:0] py_q, pcb_q, pcr_q;
   logic signed [ACC_W-1:0]  cst_q;
   logic signed [ACC_W-1:0]  cst_ext;
   logic                     v1_q;

   assign cst_ext = ACC_W'($signed(k_ofs));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_q  <= 1'b0;
         py_q  <= '0;
         pcb_q <= '0;
         pcr_q <= '0;
         cst_q <= '0;
      end else begin
         v1_q  <= in_valid;
         py_q  <= $signed({1'b0, y_i})  * $signed(k_y);
         pcb_q <= $signed({1'b0, cb_i}) * $signed(k_cb);
         pcr_q <= $signed({1'b0, cr_i}) * $signed(k_cr);
         cst_q <= cst_ext <<< SH;
      end
   end

   // stage 2: accumulate
   logic signed [ACC_W-1:0] acc_q;
   logic                    v2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v2_q  <= 1'b0;
         acc_q <= '0;
      end else begin
         v2_q  <= v1_q;
         acc_q <= ACC_W'(py_q) + ACC_W'(pcb_q) + ACC_W'(pcr_q) + cst_q;
      end
   end

   // stage 3: round, scale down, saturate
   logic signed [ACC_W-1:0] rnd, quo;
   logic [PIX_W-1:0]        ch_d;

   if (ROUND_NEAREST) begin : g_round
      localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
      assign rnd = acc_q + HALF;
   end else begin : g_trunc
      assign rnd = acc_q;
   end

   assign quo = rnd >>> FRAC;

   always_comb begin
      if (quo < 0)
         ch_d = '0;
      else if (quo > MAXV)
         ch_d = '1;
      else
         ch_d = quo[PIX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_ch    <= '0;
      end else begin
         out_valid <= v2_q;
         out_ch    <= ch_d;
      end
   end

   AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (v2_q && acc_q < 0) |=> (out_ch == '0));                          // R5

   AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (v2_q && acc_q >= HI_LIM) |=> (out_ch == '1));                    // R5

endmodule

// File: rtl/ycc_rgb_cvt.sv
module ycc_rgb_cvt
   import ycc_rgb_pkg::*;
#(
   parameter int PIX_W         = 8,
   parameter int MUL_W         = 13,
   parameter int OFS_W         = 14,
   parameter int FRAC          = 10,
   parameter int OFS_FRAC      = 4,
   parameter int CFG_AW        = 4,
   parameter int CFG_DW        = 16,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_AW-1:0]    cfg_addr,
   input  logic [CFG_DW-1:0]    cfg_wdata,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [4*PIX_W-1:0]   in_data,
   output logic                 out_valid,
   output logic [3*PIX_W-1:0]   out_rgb
);

   logic [N_ROWS*3*MUL_W-1:0] mul_flat;
   logic [N_ROWS*OFS_W-1:0]   ofs_flat;
   ycc_order_e                order;
   logic                      pix_valid;
   logic [PIX_W-1:0]          pix_y, pix_cb, pix_cr;
   logic [N_ROWS-1:0]         row_valid;

   ycc_coef_bank #(
      .MUL_W  (MUL_W),
      .OFS_W  (OFS_W),
      .CFG_AW (CFG_AW),
      .CFG_DW (CFG_DW)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .mul_flat  (mul_flat),
      .ofs_flat  (ofs_flat),
      .order_o   (order)
   );

   ycc_pair_unpack #(
      .PIX_W (PIX_W)
   ) u_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .order_i   (order),
      .pix_valid (pix_valid),
      .pix_y     (pix_y),
      .pix_cb    (pix_cb),
      .pix_cr    (pix_cr)
   );

   for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      localparam int SLOT = (r == ROW_R) ? 2 : (r == ROW_G) ? 1 : 0;
      logic [PIX_W-1:0] ch;

      ycc_mac_row #(
         .PIX_W         (PIX_W),
         .MUL_W         (MUL_W),
         .OFS_W         (OFS_W),
         .FRAC          (FRAC),
         .OFS_FRAC      (OFS_FRAC),
         .ROUND_NEAREST (ROUND_NEAREST)
      ) u_mac (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (pix_valid),
         .y_i       (pix_y),
         .cb_i      (pix_cb),
         .cr_i      (pix_cr),
         .k_y       (mul_flat[(r*3+0)*MUL_W +: MUL_W]),
         .k_cb      (mul_flat[(r*3+1)*MUL_W +: MUL_W]),
         .k_cr      (mul_flat[(r*3+2)*MUL_W +: MUL_W]),
         .k_ofs     (ofs_flat[r*OFS_W +: OFS_W]),
         .out_valid (row_valid[r]),
         .out_ch    (ch)
      );

      assign out_rgb[SLOT*PIX_W +: PIX_W] = ch;
   end

   assign out_valid = row_valid[0];

   AST_ROWS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid[1] == row_valid[0]) && (row_valid[2] == row_valid[0]));   // R8

   AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(pix_valid, 3));                                    // R8

endmodule

// File: tb/ycc_rgb_cvt_bench.sv
module ycc_rgb_cvt_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic [23:0] out_rgb;

   ycc_rgb_cvt u_ycc_rgb_cvt (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_rgb   (out_rgb)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 1'b0;
   bit    just_acc = 1'b0;
   int    kmul [3][3];
   int    kofs [3];
   int    ord = 0;
   int    seed = 7;
   int    q_rgb [$];
   int    q_cyc [$];
   string q_tag [$];

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int sx(input int raw, input int w);
      int m;
      m = raw & ((1 << w) - 1);
      if (m >= (1 << (w - 1))) m = m - (1 << w);
      return m;
   endfunction

   function automatic int chan(input int r, input int y, input int u, input int v);
      int acc, q;
      acc = y*kmul[r][0] + u*kmul[r][1] + v*kmul[r][2] + kofs[r]*64;
      q = (acc + 512) >>> 10;
      if (q < 0) q = 0;
      if (q > 255) q = 255;
      return q;
   endfunction

   function automatic int rgb(input int y, input int u, input int v);
      return (chan(1, y, u, v) << 16) | (chan(0, y, u, v) << 8) | chan(2, y, u, v);
   endfunction

   function automatic logic [31:0] pack(input int o, input int y0, input int y1,
                                        input int u, input int v);
      case (o)
         0:       return {8'(v),  8'(y1), 8'(u),  8'(y0)};
         1:       return {8'(u),  8'(y1), 8'(v),  8'(y0)};
         2:       return {8'(y1), 8'(v),  8'(y0), 8'(u)};
         default: return {8'(y1), 8'(u),  8'(y0), 8'(v)};
      endcase
   endfunction

   function automatic int rnd8();
      seed = seed * 1103515245 + 12345;
      return (seed >>> 16) & 8'hFF;
   endfunction

   task automatic step_negedge();
      @(negedge clk);
      if (just_acc) begin
         check(in_ready == 1'b0, "R9", "in_ready after accept", in_ready, 0);
         just_acc = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) step_negedge();
   endtask

   task automatic cfg_write(input int addr, input int data);
      step_negedge();
      cfg_we    = 1'b1;
      cfg_addr  = 4'(addr);
      cfg_wdata = 16'(data);
      step_negedge();
      cfg_we    = 1'b0;
      if (addr < 12) begin
         if ((addr % 4) < 3) kmul[addr/4][addr%4] = sx(data, 13);
         else                kofs[addr/4] = sx(data, 14);
      end else if (addr == 12) begin
         ord = data & 3;
      end
   endtask

   task automatic send_word(input int y0, input int y1, input int u, input int v,
                            input string tag);
      int acc;
      step_negedge();
      in_valid = 1'b1;
      in_data  = pack(ord, y0, y1, u, v);
      while (!in_ready) step_negedge();
      @(posedge clk);
      #1;
      acc      = cyc;
      in_valid = 1'b0;
      just_acc = 1'b1;
      q_rgb.push_back(rgb(y0, u, v)); q_cyc.push_back(acc + 3); q_tag.push_back(tag);
      q_rgb.push_back(rgb(y1, u, v)); q_cyc.push_back(acc + 4); q_tag.push_back(tag);
   endtask

   always @(negedge clk) begin
      if (rst_n && !done && out_valid) begin
         if (q_rgb.size() == 0) begin
            check(1'b0, "R8", "unexpected out_valid", 1, 0);
         end else begin
            int    e, ec;
            string t;
            e  = q_rgb.pop_front();
            ec = q_cyc.pop_front();
            t  = q_tag.pop_front();
            check(out_rgb == 24'(e), t, "rgb", int'(out_rgb), e);
            check(cyc == ec, "R8", "arrival cycle", cyc, ec);
         end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      kmul = '{'{1191, -401, -833}, '{1191, 0, 1634}, '{1191, 2066, 0}};
      kofs = '{2167, -3567, -4431};
      ord  = 0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

      // R1 R2 R7: reset matrix over the video range
      for (int y = 16; y <= 235; y += 9)
         for (int u = 16; u <= 240; u += 16)
            for (int v = 16; v <= 240; v += 16) begin
               send_word(y, 251 - y, u, v, "R2");
               if (((y + u + v) % 7) == 0) idle(1);
            end

      // R5: saturation at extremes
      for (int y = 0; y < 2; y++)
         for (int u = 0; u < 2; u++)
            for (int v = 0; v < 2; v++)
               send_word(y*255, 255 - y*255, u*255, v*255, "R5");
      idle(8);

      // R6: byte orders, upper data bits ignored
      for (int o = 1; o < 4; o++) begin
         cfg_write(12, 16'hFFF0 | o);
         for (int i = 0; i < 20; i++) send_word(rnd8(), rnd8(), rnd8(), rnd8(), "R6");
         idle(8);
      end

      // R3: row and term mapping
      for (int a = 0; a < 12; a++) cfg_write(a, 0);
      cfg_write(1, 1024);   // G <- Cb
      cfg_write(6, 1024);   // R <- Cr
      cfg_write(8, 1024);   // B <- Y
      cfg_write(12, 0);
      for (int i = 0; i < 20; i++) send_word(rnd8(), rnd8(), rnd8(), rnd8(), "R3");
      idle(8);

      // R2: half-step rounding over every Y
      for (int a = 0; a < 12; a++) cfg_write(a, 0);
      cfg_write(0, 512);
      cfg_write(4, 16'hFE00 | 13'h1E00);
      cfg_write(7, 16'hC000 | 14'h0008);
      for (int y = 0; y < 256; y += 2) send_word(y, y + 1, rnd8(), rnd8(), "R2");
      idle(8);

      // R4: random coefficient sets with junk high bits
      for (int s = 0; s < 12; s++) begin
         for (int a = 0; a < 12; a++) cfg_write(a, (rnd8() << 8) | rnd8());
         cfg_write(12, s);
         for (int i = 0; i < 40; i++) send_word(rnd8(), rnd8(), rnd8(), rnd8(), "R4");
         idle(8);
      end

      // R10: writes above the map leave everything untouched
      cfg_write(13, 16'h0000);
      cfg_write(14, 16'h1FFF);
      cfg_write(15, 16'h0003);
      for (int i = 0; i < 30; i++) send_word(rnd8(), rnd8(), rnd8(), rnd8(), "R10");
      idle(8);

      // R9: sustained back-to-back words
      for (int i = 0; i < 50; i++) send_word(rnd8(), rnd8(), rnd8(), rnd8(), "R9");
      idle(10);

      check(q_rgb.size() == 0, "R8", "pixels still expected", q_rgb.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule